// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block is a 16-bit timer counter whose behaviour is chosen by a 4-bit mode field. The block has no prescaler. In its plain mode it counts every system clock cycle while enabled. The other modes do one of the following:

- decode two quadrature channel inputs as an encoder;
- let a trigger input gate the count, start it, clock it or clear it.

The trigger is XORed with a polarity bit before any sampling, so either pin edge can be made the active one.

The channel inputs and the effective trigger are registered on the system clock. Edges are found by comparing each sample with the one before it. A counter step, a reload or a clear happens on the second rising clock edge after an input changes.

The counter runs from 0 up to the auto-reload value and wraps in both directions. Every wrap and every trigger-driven reinitialisation gives a one-cycle update pulse. The live enable state is an output. It is set by the software enable or by a start trigger, and it is cleared when the software enable falls.

Top module: `tsm_slave_timer`

## Requirements
- R1: During and right after reset, count_o is 0, and dir_down_o, update_o and run_o are 0.
- R2: With mode 0 and with every code from 9 to 15, the counter moves up by one on each clock cycle in which the enable state is 1. The first step comes one cycle after run_o rises. Nothing moves while run_o is 0.
- R3: Wrap in the up direction:
  - A step up from a value equal to or above arr_i loads 0.
  - In the same cycle update_o is 1 for exactly one cycle.
- R4: In mode 1, only TI1 edges are counted. The step is up when the new TI1 level differs from the TI2 level, and down otherwise. dir_down_o shows 1 after a down step and 0 after an up step. It keeps its value across edges that are not counted. So a forward quadrature sequence (00, 10, 11, 01, shown as TI1 then TI2) counts up.
- R5: In mode 2, only TI2 edges are counted. The step is up when the new TI2 level equals the TI1 level, and down otherwise.
- R6: In mode 3, every single-input edge is counted by the rules of R4 and R5. A cycle in which both inputs change together gives no step. In every mode other than 1 to 3, dir_down_o is 0.
- R7: In mode 4, the counter counts each cycle while enabled. An active trigger edge clears the counter to 0 and pulses update_o, whether or not the block is enabled. A trigger that stays high clears the counter only once.
- R8: In mode 5, the counter steps once per enabled cycle in which the sampled effective trigger is 1. It holds its value, without clearing, while the trigger is 0.
- R9: In mode 6, an active trigger edge sets run_o on the next cycle, and the count carries on from its old value. Only the start is under trigger control.
- R10: In mode 7, each active trigger edge moves the counter up by one while the block is enabled. In this mode the internal clock cycles are not counted.
- R11: In mode 8, one active trigger edge does three things in the same cycle: it clears the counter to 0, pulses update_o and sets run_o.
- R12: The effective trigger is trig_i XOR trig_pol_i. With trig_pol_i = 1, a falling pin edge is the active edge, and a rising pin edge has no effect.
- R13: run_o becomes 1 on the clock edge where sw_en_i is first seen high, and it stays 1 while sw_en_i is high. A falling sw_en_i clears it on the next edge unless a start trigger comes in the same cycle.
- R14: Wrap in the down direction:
  - A step down from 0 loads arr_i.
  - In the same cycle update_o is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Slave mode code (codes 9 to 15 act as 0) |
| sw_en_i | input | 1 | Software counter enable |
| trig_i | input | 1 | Trigger input pin |
| trig_pol_i | input | 1 | Trigger polarity: 1 makes the falling pin edge active |
| ti1_i | input | 1 | First filtered channel input |
| ti2_i | input | 1 | Second filtered channel input |
| arr_i | input | 16 | Auto-reload value, the top of the count range |
| count_o | output | 16 | Counter value |
| dir_down_o | output | 1 | 1 after an encoder step down |
| update_o | output | 1 | One-cycle update event: wrap or reinitialisation |
| run_o | output | 1 | Live counter enable state |

## Verification
A wrong sample or history bit shows up two clock edges after the faulty input change. It appears as one of these:
- a count step that is missing or extra;
- a step in the wrong direction;
- a reload that is missing or extra.

A wrong enable state shows up one edge later, as a count that goes on or stops. A wrong wrap decision is seen in the same cycle as count_o and update_o disagreeing with each other.

Sweeping every reload value from 0 to 5 and every encoder transition, in both directions and with counted and uncounted edges mixed, catches such errors within a few cycles of the point where they arise.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    localparam int MODE_W = 4;
    localparam int NUM_IN = 3;
    localparam int IDX_TI1 = 0;
    localparam int IDX_TI2 = 1;
    localparam int IDX_TRG = 2;

    typedef enum logic [MODE_W-1:0] {
        M_OFF    = 4'd0,
        M_ENC1   = 4'd1,
        M_ENC2   = 4'd2,
        M_ENC3   = 4'd3,
        M_RESET  = 4'd4,
        M_GATED  = 4'd5,
        M_TRIG   = 4'd6,
        M_EXTCLK = 4'd7,
        M_COMBO  = 4'd8
    } mode_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic reinit;
    } step_cmd_t;

    function automatic mode_e decode_mode(input logic [MODE_W-1:0] raw);
        if (raw > 4'd8) begin
            return M_OFF;
        end
        return mode_e'(raw);
    endfunction

    function automatic logic is_encoder(input mode_e m);
        return (m == M_ENC1) || (m == M_ENC2) || (m == M_ENC3);
    endfunction

endpackage

// File: rtl/tsm_sampler.sv
module tsm_sampler #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] chg_o
);

    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prv;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d     = smp_q;
        smp_d.cur = in_i;
        smp_d.prv = smp_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign lvl_o[g]  = smp_q.cur[g];
        assign rise_o[g] = smp_q.cur[g] & ~smp_q.prv[g];
        assign chg_o[g]  = smp_q.cur[g] ^ smp_q.prv[g];
    end

endmodule

// File: rtl/tsm_mode.sv
module tsm_mode
    import tsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_raw_i,
    input  logic              sw_en_i,
    input  logic [1:0]        ti_lvl_i,
    input  logic [1:0]        ti_chg_i,
    input  logic              trg_lvl_i,
    input  logic              trg_rise_i,
    output step_cmd_t         cmd_o,
    output logic              run_o,
    output logic              dir_down_o
);

    typedef struct packed {
        logic run;
        logic sw_prv;
        logic dir;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    mode_e     mode;
    step_cmd_t cmd;
    logic      start_evt;
    logic      sw_fall;
    logic      enc_hit;
    logic      enc_up;

    always_comb begin
        mode      = decode_mode(mode_raw_i);
        start_evt = trg_rise_i && ((mode == M_TRIG) || (mode == M_COMBO));
        sw_fall   = !sw_en_i && ctl_q.sw_prv;

        ctl_d        = ctl_q;
        ctl_d.sw_prv = sw_en_i;
        if (sw_en_i) begin
            ctl_d.run = 1'b1;
        end else if (start_evt) begin
            ctl_d.run = 1'b1;
        end else if (sw_fall) begin
            ctl_d.run = 1'b0;
        end

        cmd     = '0;
        enc_hit = 1'b0;
        enc_up  = 1'b0;
        case (mode)
            M_ENC1: begin
                enc_hit = ti_chg_i[0];
                enc_up  = ti_lvl_i[0] != ti_lvl_i[1];
            end
            M_ENC2: begin
                enc_hit = ti_chg_i[1];
                enc_up  = ti_lvl_i[1] == ti_lvl_i[0];
            end
            M_ENC3: begin
                enc_hit = ti_chg_i[0] ^ ti_chg_i[1];
                if (ti_chg_i[0]) begin
                    enc_up = ti_lvl_i[0] != ti_lvl_i[1];
                end else begin
                    enc_up = ti_lvl_i[1] == ti_lvl_i[0];
                end
            end
            M_RESET, M_COMBO: begin
                if (trg_rise_i) begin
                    cmd.reinit = 1'b1;
                end else begin
                    cmd.up = ctl_q.run;
                end
            end
            M_GATED:  cmd.up = ctl_q.run && trg_lvl_i;
            M_EXTCLK: cmd.up = ctl_q.run && trg_rise_i;
            default:  cmd.up = ctl_q.run;
        endcase

        if (enc_hit && ctl_q.run) begin
            cmd.up = enc_up;
            cmd.dn = !enc_up;
        end

        if (!is_encoder(mode)) begin
            ctl_d.dir = 1'b0;
        end else if (cmd.up || cmd.dn) begin
            ctl_d.dir = cmd.dn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_o      = cmd;
    assign run_o      = ctl_q.run;
    assign dir_down_o = ctl_q.dir;

    // R8: a low gate in mode 5 never lets a step through
    p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_raw_i == 4'd5 && !trg_lvl_i) |-> !(cmd_o.up || cmd_o.dn));

    // R13 and R9: enable rises only from software or from a start trigger
    p_start_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> ($past(sw_en_i)
                          || $past(trg_rise_i && (mode_raw_i == 4'd6 || mode_raw_i == 4'd8))));

    // R6: outside the encoder modes the direction flag reads 0
    p_dir_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_raw_i == 4'd0 || mode_raw_i > 4'd3) |=> !dir_down_o);

endmodule

// File: rtl/tsm_counter.sv
module tsm_counter
    import tsm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  step_cmd_t     cmd_i,
    input  logic [CW-1:0] arr_i,
    output logic [CW-1:0] cnt_o,
    output logic          upd_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          upd;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.upd = 1'b0;
        if (cmd_i.reinit) begin
            cnt_d.cnt = '0;
            cnt_d.upd = 1'b1;
        end else if (cmd_i.up) begin
            if (cnt_q.cnt >= arr_i) begin
                cnt_d.cnt = '0;
                cnt_d.upd = 1'b1;
            end else begin
                cnt_d.cnt = cnt_q.cnt + ONE;
            end
        end else if (cmd_i.dn) begin
            if (cnt_q.cnt == '0) begin
                cnt_d.cnt = arr_i;
                cnt_d.upd = 1'b1;
            end else begin
                cnt_d.cnt = cnt_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q.cnt;
    assign upd_o = cnt_q.upd;

    // R7: the mode logic asks for at most one action per cycle
    p_one_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_i.up, cmd_i.dn, cmd_i.reinit}));

    // R3 and R14: an update leaves the counter at one of the two range ends
    p_wrap_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (cnt_o == '0 || cnt_o == $past(arr_i)));

    // R2: without an update the counter moves by one at most
    p_step_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_o && cnt_o != $past(cnt_o)) |->
            (cnt_o == $past(cnt_o) + ONE || cnt_o == $past(cnt_o) - ONE));

    // R11: a reinitialisation clears the counter and pulses update
    p_reinit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.reinit |=> (cnt_o == '0 && upd_o));

endmodule

// File: rtl/tsm_slave_timer.sv
module tsm_slave_timer
    import tsm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              sw_en_i,
    input  logic              trig_i,
    input  logic              trig_pol_i,
    input  logic              ti1_i,
    input  logic              ti2_i,
    input  logic [CNT_W-1:0]  arr_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              dir_down_o,
    output logic              update_o,
    output logic              run_o
);

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] lvl;
    logic [NUM_IN-1:0] rise;
    logic [NUM_IN-1:0] chg;
    step_cmd_t         cmd;

    always_comb begin
        raw_in          = '0;
        raw_in[IDX_TI1] = ti1_i;
        raw_in[IDX_TI2] = ti2_i;
        raw_in[IDX_TRG] = trig_i ^ trig_pol_i;
    end

    tsm_sampler #(.W(NUM_IN)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (raw_in),
        .lvl_o  (lvl),
        .rise_o (rise),
        .chg_o  (chg)
    );

    tsm_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_raw_i (mode_i),
        .sw_en_i    (sw_en_i),
        .ti_lvl_i   ({lvl[IDX_TI2], lvl[IDX_TI1]}),
        .ti_chg_i   ({chg[IDX_TI2], chg[IDX_TI1]}),
        .trg_lvl_i  (lvl[IDX_TRG]),
        .trg_rise_i (rise[IDX_TRG]),
        .cmd_o      (cmd),
        .run_o      (run_o),
        .dir_down_o (dir_down_o)
    );

    tsm_counter #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (cmd),
        .arr_i (arr_i),
        .cnt_o (count_o),
        .upd_o (update_o)
    );

    logic unused_rise_ti;
    assign unused_rise_ti = rise[IDX_TI1] ^ rise[IDX_TI2] ^ chg[IDX_TRG];

endmodule

// File: tb/sim_tsm_slave_timer.sv
`timescale 1ns/1ps
module sim_tsm_slave_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        sw_en = 1'b0;
    logic        trig = 1'b0;
    logic        trig_pol = 1'b0;
    logic        ti1 = 1'b0;
    logic        ti2 = 1'b0;
    logic [15:0] arr = 16'd0;
    logic [15:0] count;
    logic        dir_down;
    logic        update;
    logic        run;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsm_slave_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .sw_en_i    (sw_en),
        .trig_i     (trig),
        .trig_pol_i (trig_pol),
        .ti1_i      (ti1),
        .ti2_i      (ti2),
        .arr_i      (arr),
        .count_o    (count),
        .dir_down_o (dir_down),
        .update_o   (update),
        .run_o      (run)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] m, input int a, input logic pol, input logic trg);
        rst_n    = 1'b0;
        sw_en    = 1'b0;
        mode     = m;
        arr      = 16'(a);
        trig_pol = pol;
        trig     = trg;
        ti1      = 1'b0;
        ti2      = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    function automatic logic q1(input int idx);
        return (idx == 1) || (idx == 2);
    endfunction

    function automatic logic q2(input int idx);
        return idx >= 2;
    endfunction

    task automatic sweep_internal(input logic [3:0] m, input int a, input string tag);
        do_reset(m, a, 1'b0, 1'b0);
        sw_en = 1'b1;
        tick(1);
        chk({tag, " start"}, int'(count), 0);
        for (int j = 1; j <= 12; j++) begin
            tick(1);
            chk({tag, " count"}, int'(count), j % (a + 1));
            chk({"R3 ", tag, " update"}, int'(update), ((j % (a + 1)) == 0) ? 1 : 0);
        end
    endtask

    task automatic run_enc(input logic [3:0] m);
        int    idx;
        int    nidx;
        int    c;
        int    d;
        bit    fwd;
        bit    counted;
        bit    u;
        string tag;
        tag = (m == 4'd1) ? "R4 enc1" : (m == 4'd2) ? "R5 enc2" : "R6 enc3";
        do_reset(m, 5, 1'b0, 1'b0);
        sw_en = 1'b1;
        tick(2);
        idx = 0;
        c   = 0;
        d   = 0;
        for (int k = 0; k < 40; k++) begin
            fwd  = (k < 14) ? 1'b1 : (k < 28) ? 1'b0 : ((k % 3) != 0);
            nidx = fwd ? (idx + 1) % 4 : (idx + 3) % 4;
            if (m == 4'd1) begin
                counted = q1(idx) != q1(nidx);
            end else if (m == 4'd2) begin
                counted = q2(idx) != q2(nidx);
            end else begin
                counted = 1'b1;
            end
            u = 1'b0;
            if (counted) begin
                if (fwd) begin
                    if (c >= 5) begin
                        c = 0;
                        u = 1'b1;
                    end else begin
                        c = c + 1;
                    end
                    d = 0;
                end else begin
                    if (c == 0) begin
                        c = 5;
                        u = 1'b1;
                    end else begin
                        c = c - 1;
                    end
                    d = 1;
                end
            end
            ti1 = q1(nidx);
            ti2 = q2(nidx);
            idx = nidx;
            tick(2);
            chk({tag, " count"}, int'(count), c);
            chk(u && !fwd ? {"R14 ", tag, " update"} : {tag, " update"}, int'(update), u ? 1 : 0);
            chk({"R6 ", tag, " dir"}, int'(dir_down), d);
        end
    endtask

    initial begin
        tick(1);
        chk("R1 reset count", int'(count), 0);
        chk("R1 reset dir", int'(dir_down), 0);
        chk("R1 reset update", int'(update), 0);
        chk("R1 reset run", int'(run), 0);

        // R13 and R2: enable and disable latency in mode 0
        do_reset(4'd0, 1000, 1'b0, 1'b0);
        chk("R1 after reset run", int'(run), 0);
        sw_en = 1'b1;
        tick(1);
        chk("R13 run rises", int'(run), 1);
        chk("R2 first count", int'(count), 0);
        tick(5);
        chk("R2 five steps", int'(count), 5);
        sw_en = 1'b0;
        tick(1);
        chk("R13 run cleared", int'(run), 0);
        chk("R2 last step", int'(count), 6);
        tick(3);
        chk("R2 holds while stopped", int'(count), 6);

        // R2 and R3: reload sweep, plus reserved codes
        for (int a = 0; a <= 5; a++) begin
            sweep_internal(4'd0, a, "R2 mode0");
        end
        sweep_internal(4'd9, 3, "R2 code9");
        sweep_internal(4'd13, 2, "R2 code13");
        sweep_internal(4'd15, 4, "R2 code15");

        // R4 R5 R6 R14: encoder modes
        run_enc(4'd1);
        run_enc(4'd2);
        run_enc(4'd3);

        // R6: both inputs changing in one cycle give no step
        do_reset(4'd3, 5, 1'b0, 1'b0);
        sw_en = 1'b1;
        tick(2);
        ti1 = 1'b1;
        ti2 = 1'b1;
        tick(3);
        chk("R6 simultaneous rise ignored", int'(count), 0);
        ti1 = 1'b0;
        ti2 = 1'b0;
        tick(3);
        chk("R6 simultaneous fall ignored", int'(count), 0);

        // R7: reset mode
        do_reset(4'd4, 1000, 1'b0, 1'b0);
        sw_en = 1'b1;
        tick(1);
        tick(10);
        chk("R7 counting", int'(count), 10);
        trig = 1'b1;
        tick(1);
        chk("R7 before clear", int'(count), 11);
        tick(1);
        chk("R7 cleared", int'(count), 0);
        chk("R7 update", int'(update), 1);
        tick(1);
        chk("R7 resumes", int'(count), 1);
        chk("R7 update one cycle", int'(update), 0);
        tick(3);
        chk("R7 high trigger clears once", int'(count), 4);

        // R8: gated mode
        do_reset(4'd5, 1000, 1'b0, 1'b0);
        sw_en = 1'b1;
        tick(6);
        chk("R8 closed gate", int'(count), 0);
        trig = 1'b1;
        tick(7);
        trig = 1'b0;
        tick(5);
        chk("R8 seven gated cycles", int'(count), 7);
        trig = 1'b1;
        tick(3);
        trig = 1'b0;
        tick(4);
        chk("R8 no clear between gates", int'(count), 10);

        // R9: trigger-start mode
        do_reset(4'd6, 1000, 1'b0, 1'b0);
        tick(5);
        chk("R9 idle run", int'(run), 0);
        chk("R9 idle count", int'(count), 0);
        trig = 1'b1;
        tick(2);
        chk("R9 started", int'(run), 1);
        chk("R9 no reset", int'(count), 0);
        tick(4);
        chk("R9 counting", int'(count), 4);
        trig = 1'b0;
        sw_en = 1'b1;
        tick(1);
        sw_en = 1'b0;
        tick(1);
        chk("R13 fall stops", int'(run), 0);
        tick(3);
        chk("R9 held value", int'(count), 6);
        trig = 1'b1;
        tick(2);
        chk("R9 restarted", int'(run), 1);
        chk("R9 kept value", int'(count), 6);
        tick(3);
        chk("R9 continues", int'(count), 9);

        // R10: external clock on trigger
        do_reset(4'd7, 1000, 1'b0, 1'b0);
        sw_en = 1'b1;
        tick(5);
        chk("R10 no internal counting", int'(count), 0);
        for (int p = 1; p <= 6; p++) begin
            trig = 1'b1;
            tick(2);
            chk("R10 pulse counted", int'(count), p);
            trig = 1'b0;
            tick(3);
        end
        sw_en = 1'b0;
        tick(2);
        trig = 1'b1;
        tick(2);
        trig = 1'b0;
        tick(2);
        chk("R10 disabled ignores pulse", int'(count), 6);

        // R11: combined reset and start
        do_reset(4'd8, 1000, 1'b0, 1'b0);
        tick(3);
        chk("R11 idle", int'(run), 0);
        trig = 1'b1;
        tick(2);
        chk("R11 run set", int'(run), 1);
        chk("R11 cleared", int'(count), 0);
        chk("R11 update", int'(update), 1);
        tick(1);
        chk("R11 first step", int'(count), 1);
        chk("R11 update one cycle", int'(update), 0);
        tick(4);
        chk("R11 counting", int'(count), 5);
        trig = 1'b0;
        tick(2);
        trig = 1'b1;
        tick(1);
        chk("R11 before second clear", int'(count), 8);
        tick(1);
        chk("R11 second clear", int'(count), 0);
        chk("R11 second update", int'(update), 1);

        // R12: inverted polarity
        do_reset(4'd7, 1000, 1'b1, 1'b1);
        sw_en = 1'b1;
        tick(4);
        chk("R12 idle high pin", int'(count), 0);
        trig = 1'b0;
        tick(2);
        chk("R12 falling pin counts", int'(count), 1);
        trig = 1'b1;
        tick(3);
        chk("R12 rising pin ignored", int'(count), 1);
        trig = 1'b0;
        tick(2);
        chk("R12 second falling pin", int'(count), 2);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule